// File: doc/BRIEF.md
# UART Interrupt Request and DMA Ready Controller

This block sits beside the receive and transmit FIFOs of a UART channel and turns their occupancy, the receive line status and the modem change flags into four interrupt requests and a combined interrupt line. It holds the per-source interrupt enables, a FIFO enable bit and a DMA mode select bit. It also drives two active-low DMA handshake pins, one for transmit and one for receive.

The host writes the enables and the mode bits through two write strobes. The FIFO logic supplies its occupancy counts and the receive trigger level. The host interface supplies a strobe for each read of the interrupt status and for each write of transmit data. All outputs are registered, so each one reflects its cause one clock later. The DMA pins follow one rule for single-transfer operation (mode 0, or FIFOs disabled) and a second rule for block transfers (mode 1 with FIFOs enabled).

Top module: `uart_irq_dma_ctrl`

## Requirements
- R1: While the synchronous reset is high, all four requests and `irq` are 0, `txrdy_n` and `rxrdy_n` are 1, and the enables, FIFO enable and DMA mode all read as 0.
- R2: A write to `ien_wr` loads `ien_wdata`. Bit 0 enables the receive-ready request, bit 1 the transmit-empty request, bit 2 the line status request and bit 3 the modem request. A request whose enable bit is 0 stays low whatever its cause.
- R3: With FIFOs enabled, `rx_irq` is 1 exactly when `rx_count >= rx_trig` (trigger 1..depth), one clock after the inputs.
- R4: With FIFOs disabled, `rx_irq` is 1 exactly when `rx_count` is non-zero, and `rx_trig` has no effect.
- R5: A transmit-empty request is latched when `tx_count` changes from non-zero to zero. A pulse on `isr_rd` or `thr_wr` clears it. If a clear pulse arrives in the same clock as the change to empty, the request is still latched.
- R6: `ls_irq` is 1 when any bit of `line_err` is set, and `ms_irq` is 1 when any bit of `modem_chg` is set.
- R7: `irq` is the OR of the four enabled requests and is registered one clock after the cause. With all enables at 0, `irq` stays 0 (polled use).
- R8: In mode 0, or with FIFOs disabled, `txrdy_n` is 0 when `tx_count` is 0 and 1 otherwise.
- R9: In mode 0, or with FIFOs disabled, `rxrdy_n` is 0 when `rx_count` is non-zero and 1 when it is zero.
- R10: In mode 1, `txrdy_n` is 1 only when `tx_count` equals the FIFO depth, and 0 otherwise.
- R11: In mode 1, `rxrdy_n` falls when `rx_count >= rx_trig` or `rx_timeout` is 1, rises when `rx_count` is 0, and otherwise holds its value.
- R12: Mode 1 takes effect only when FIFOs are enabled. With FIFOs disabled, the DMA mode bit has no effect on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ien_wr | input | 1 | Load the enable register |
| ien_wdata | input | 4 | Enable bits: rx ready, tx empty, line status, modem |
| mode_wr | input | 1 | Load the FIFO enable and DMA mode bits |
| mode_fifo_en | input | 1 | FIFO enable value |
| mode_dma | input | 1 | DMA mode value (0 single, 1 block) |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_trig | input | CNT_W | Receive trigger level |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_timeout | input | 1 | Receive time-out flag |
| line_err | input | 4 | Receive error and break status bits |
| modem_chg | input | 4 | Modem change bits |
| isr_rd | input | 1 | Host read of interrupt status |
| thr_wr | input | 1 | Host write of transmit data |
| rx_irq | output | 1 | Receive-ready request |
| tx_irq | output | 1 | Transmit-empty request |
| ls_irq | output | 1 | Line status request |
| ms_irq | output | 1 | Modem status request |
| irq | output | 1 | Combined interrupt |
| txrdy_n | output | 1 | Transmit DMA ready, active low |
| rxrdy_n | output | 1 | Receive DMA ready, active low |

## Verification
The bench builds the block with a FIFO depth of 4, so the counts are 3 bits wide. At that depth every pair of count and trigger level can be swept in both FIFO modes, every full/empty boundary in both DMA modes can be reached, and all sixteen enable masks can be combined with every mix of causes. The mode 1 receive hysteresis is walked up and down through the trigger level, and is also triggered by the time-out.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IEN_W = 4;
  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;

  typedef struct packed {
    logic ms;
    logic ls;
    logic tx;
    logic rx;
  } irq_vec_t;
endpackage

// File: rtl/uart_irq_cfg.sv
module uart_irq_cfg
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ien_wr,
  input  logic [IEN_W-1:0] ien_wdata,
  input  logic             mode_wr,
  input  logic             mode_fifo_en,
  input  logic             mode_dma,
  output logic [IEN_W-1:0] ien_q,
  output logic             fifo_en_q,
  output logic             dma_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q     <= '0;
      fifo_en_q <= 1'b0;
      dma_q     <= 1'b0;
    end else begin
      if (ien_wr) ien_q <= ien_wdata;
      if (mode_wr) begin
        fifo_en_q <= mode_fifo_en;
        dma_q     <= mode_dma;
      end
    end
  end

  assert_cfg_reset_R1: assert property (@(posedge clk)
    $past(rst) && !$past(ien_wr) |-> ien_q == '0 || !rst);
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IEN_W-1:0] ien,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [3:0]       line_err,
  input  logic [3:0]       modem_chg,
  input  logic             isr_rd,
  input  logic             thr_wr,
  output irq_vec_t         req_q,
  output logic             irq_q
);
  logic     tx_empty, tx_empty_d, tx_rise, tx_pend, pend_nxt, rx_cond;
  irq_vec_t raw, gated;
  logic     past_ok;

  assign tx_empty = (tx_count == '0);
  assign tx_rise  = tx_empty && !tx_empty_d;

  always_comb begin
    if (tx_rise)               pend_nxt = 1'b1;
    else if (isr_rd || thr_wr) pend_nxt = 1'b0;
    else                       pend_nxt = tx_pend;
  end

  assign rx_cond = fifo_en ? (rx_count >= rx_trig) : (rx_count != '0);

  always_comb begin
    raw.rx = rx_cond;
    raw.tx = pend_nxt;
    raw.ls = |line_err;
    raw.ms = |modem_chg;
  end

  // Per-source masking with the enable register.
  generate
    for (genvar i = 0; i < IEN_W; i++) begin : g_mask
      assign gated[i] = raw[i] & ien[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_empty_d <= 1'b1;
      tx_pend    <= 1'b0;
      req_q      <= '0;
      irq_q      <= 1'b0;
      past_ok    <= 1'b0;
    end else begin
      tx_empty_d <= tx_empty;
      tx_pend    <= pend_nxt;
      req_q      <= gated;
      irq_q      <= |gated;
      past_ok    <= 1'b1;
    end
  end

  assert_irq_or_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q == (req_q.rx | req_q.tx | req_q.ls | req_q.ms));
  assert_polled_R7: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(ien) == '0 |-> !irq_q);
  assert_tx_set_R5: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(tx_rise) && $past(ien[EN_TX]) |-> req_q.tx);
  assert_tx_clr_R5: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(isr_rd || thr_wr) && !$past(tx_rise) |-> !req_q.tx);
  assert_rx_below_R3: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(fifo_en && rx_count < rx_trig) |-> !req_q.rx);
endmodule

// File: rtl/uart_dma_rdy.sv
module uart_dma_rdy #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             dma_mode,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             rx_timeout,
  output logic             txrdy_n,
  output logic             rxrdy_n
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FIFO_DEPTH);

  logic block, tx_nxt, rx_nxt, past_ok;

  assign block = fifo_en && dma_mode;

  always_comb begin
    if (block) tx_nxt = (tx_count == FULL);
    else       tx_nxt = (tx_count != '0);
  end

  always_comb begin
    if (rx_count == '0)                               rx_nxt = 1'b1;
    else if (!block)                                  rx_nxt = 1'b0;
    else if ((rx_count >= rx_trig) || rx_timeout)     rx_nxt = 1'b0;
    else                                              rx_nxt = rxrdy_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txrdy_n <= 1'b1;
      rxrdy_n <= 1'b1;
      past_ok <= 1'b0;
    end else begin
      txrdy_n <= tx_nxt;
      rxrdy_n <= rx_nxt;
      past_ok <= 1'b1;
    end
  end

  assert_txrdy_block_R10: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(block) && $past(tx_count) != FULL |-> !txrdy_n);
  assert_rxrdy_empty_R9: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(rx_count) == '0 |-> rxrdy_n);
  assert_rxrdy_hold_R11: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(block) && $past(rx_count) != '0 &&
    $past(rx_count) < $past(rx_trig) && !$past(rx_timeout)
    |-> rxrdy_n == $past(rxrdy_n));
endmodule

// File: rtl/uart_irq_dma_ctrl.sv
module uart_irq_dma_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ien_wr,
  input  logic [IEN_W-1:0] ien_wdata,
  input  logic             mode_wr,
  input  logic             mode_fifo_en,
  input  logic             mode_dma,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             rx_timeout,
  input  logic [3:0]       line_err,
  input  logic [3:0]       modem_chg,
  input  logic             isr_rd,
  input  logic             thr_wr,
  output logic             rx_irq,
  output logic             tx_irq,
  output logic             ls_irq,
  output logic             ms_irq,
  output logic             irq,
  output logic             txrdy_n,
  output logic             rxrdy_n
);
  logic [IEN_W-1:0] ien_q;
  logic             fifo_en_q, dma_q;
  irq_vec_t         req_q;

  uart_irq_cfg u_cfg (
    .clk(clk), .rst(rst),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .mode_wr(mode_wr), .mode_fifo_en(mode_fifo_en), .mode_dma(mode_dma),
    .ien_q(ien_q), .fifo_en_q(fifo_en_q), .dma_q(dma_q)
  );

  uart_irq_src #(.CNT_W(CNT_W)) u_src (
    .clk(clk), .rst(rst), .ien(ien_q), .fifo_en(fifo_en_q),
    .rx_count(rx_count), .rx_trig(rx_trig), .tx_count(tx_count),
    .line_err(line_err), .modem_chg(modem_chg),
    .isr_rd(isr_rd), .thr_wr(thr_wr),
    .req_q(req_q), .irq_q(irq)
  );

  uart_dma_rdy #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_dma (
    .clk(clk), .rst(rst), .fifo_en(fifo_en_q), .dma_mode(dma_q),
    .rx_count(rx_count), .rx_trig(rx_trig), .tx_count(tx_count),
    .rx_timeout(rx_timeout), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
  );

  assign rx_irq = req_q.rx;
  assign tx_irq = req_q.tx;
  assign ls_irq = req_q.ls;
  assign ms_irq = req_q.ms;

  assert_ls_enable_R2: assert property (@(posedge clk) disable iff (rst)
    ls_irq |-> $past(ien_q[EN_LS]));
  assert_ms_enable_R2: assert property (@(posedge clk) disable iff (rst)
    ms_irq |-> $past(ien_q[EN_MS]));
  assert_ls_cause_R6: assert property (@(posedge clk) disable iff (rst)
    ls_irq |-> $past(line_err) != 4'd0);
endmodule

// File: tb/uart_irq_dma_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_dma_ctrl_tb;
  localparam int DEPTH = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ien_wr = 0, mode_wr = 0, mode_fifo_en = 0, mode_dma = 0;
  logic [3:0] ien_wdata = 0;
  logic [CW-1:0] rx_count = 0, rx_trig = 1, tx_count = 0;
  logic rx_timeout = 0, isr_rd = 0, thr_wr = 0;
  logic [3:0] line_err = 0, modem_chg = 0;
  logic rx_irq, tx_irq, ls_irq, ms_irq, irq, txrdy_n, rxrdy_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_irq_dma_ctrl #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .mode_wr(mode_wr), .mode_fifo_en(mode_fifo_en), .mode_dma(mode_dma),
    .rx_count(rx_count), .rx_trig(rx_trig), .tx_count(tx_count),
    .rx_timeout(rx_timeout), .line_err(line_err), .modem_chg(modem_chg),
    .isr_rd(isr_rd), .thr_wr(thr_wr),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .ls_irq(ls_irq), .ms_irq(ms_irq),
    .irq(irq), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; rx_count = 0; tx_count = 0; rx_trig = 1; rx_timeout = 0;
    line_err = 0; modem_chg = 0; isr_rd = 0; thr_wr = 0;
    tick(); tick();
    rst = 0;
  endtask

  task automatic wr_ien(input logic [3:0] v);
    ien_wr = 1; ien_wdata = v; tick(); ien_wr = 0;
  endtask

  task automatic wr_mode(input logic fe, input logic dm);
    mode_wr = 1; mode_fifo_en = fe; mode_dma = dm; tick(); mode_wr = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic exp_rx;
    // R1: reset state while reset is held
    rst = 1; line_err = 4'hF; modem_chg = 4'hF; rx_count = 2; tx_count = 0;
    tick(); tick();
    check("R1 irq", irq, 0);
    check("R1 rx_irq", rx_irq, 0);
    check("R1 ls_irq", ls_irq, 0);
    check("R1 txrdy_n", txrdy_n, 1);
    check("R1 rxrdy_n", rxrdy_n, 1);
    rst = 0; tick();
    check("R1 enables cleared, ls masked", ls_irq, 0);
    check("R1 enables cleared, ms masked", ms_irq, 0);

    // R2: each enable bit gates only its own source
    do_reset();
    line_err = 4'h2; modem_chg = 4'h8; rx_count = 1;
    for (int b = 0; b < 4; b++) begin
      wr_ien(4'(1 << b)); tick();
      check("R2 rx bit0", rx_irq, b == 0);
      check("R2 ls bit2", ls_irq, b == 2);
      check("R2 ms bit3", ms_irq, b == 3);
      check("R2 tx bit1 no edge", tx_irq, 0);
    end

    // R3: FIFO mode threshold sweep
    do_reset(); wr_ien(4'b0001); wr_mode(1, 0);
    for (int t = 1; t <= DEPTH; t++)
      for (int c = 0; c <= DEPTH; c++) begin
        rx_trig = CW'(t); rx_count = CW'(c); tick();
        check("R3 rx_irq level", rx_irq, c >= t);
        check("R3 irq follows", irq, c >= t);
      end

    // R4: non-FIFO mode, trigger ignored
    do_reset(); wr_ien(4'b0001); wr_mode(0, 0);
    for (int t = 1; t <= DEPTH; t++)
      for (int c = 0; c <= DEPTH; c++) begin
        rx_trig = CW'(t); rx_count = CW'(c); tick();
        check("R4 rx_irq holding", rx_irq, c != 0);
      end

    // R5: transmit empty latch and clears
    do_reset(); wr_ien(4'b0010);
    tx_count = 1; tick(); check("R5 not empty", tx_irq, 0);
    tx_count = 0; tick(); check("R5 set on empty", tx_irq, 1);
    tick(); check("R5 stays latched", tx_irq, 1);
    isr_rd = 1; tick(); isr_rd = 0; check("R5 cleared by status read", tx_irq, 0);
    tick(); check("R5 stays cleared", tx_irq, 0);
    tx_count = 2; tick(); tx_count = 0; tick(); check("R5 set again", tx_irq, 1);
    thr_wr = 1; tick(); thr_wr = 0; check("R5 cleared by data write", tx_irq, 0);
    tx_count = 1; tick(); tx_count = 0; thr_wr = 1; tick(); thr_wr = 0;
    check("R5 set wins over clear", tx_irq, 1);

    // R6: line and modem sweeps
    do_reset(); wr_ien(4'b1100);
    for (int v = 0; v < 16; v++) begin
      line_err = 4'(v); modem_chg = 4'(15 - v); tick();
      check("R6 ls any bit", ls_irq, v != 0);
      check("R6 ms any bit", ms_irq, v != 15);
    end

    // R7: OR of enabled sources, all masks by all cause mixes
    do_reset(); wr_mode(1, 0); rx_trig = 2;
    for (int e = 0; e < 16; e++) begin
      wr_ien(4'(e));
      for (int c = 0; c < 8; c++) begin
        rx_count = c[0] ? CW'(2) : CW'(1);
        line_err = c[1] ? 4'h4 : 4'h0;
        modem_chg = c[2] ? 4'h1 : 4'h0;
        tick();
        check("R7 irq OR", irq, (e[0] & c[0]) | (e[2] & c[1]) | (e[3] & c[2]));
      end
    end
    // R7: one clock of latency
    do_reset(); wr_ien(4'b0100); tick();
    line_err = 4'h1; #1;
    check("R7 not before edge", irq, 0);
    tick(); check("R7 after one edge", irq, 1);
    // R7: polled operation
    do_reset(); wr_mode(1, 0); wr_ien(4'b0000);
    line_err = 4'hF; modem_chg = 4'hF; rx_count = CW'(DEPTH); rx_trig = 1;
    tx_count = 1; tick(); tx_count = 0; tick();
    check("R7 polled no irq", irq, 0);

    // R8/R9 with FIFOs on, mode 0; R12 with FIFOs off and mode bit set
    for (int m = 0; m < 2; m++) begin
      do_reset();
      if (m == 0) wr_mode(1, 0); else wr_mode(0, 1);
      rx_trig = 3;
      for (int c = 0; c <= DEPTH; c++) begin
        tx_count = CW'(c); rx_count = CW'(c); tick();
        check(m == 0 ? "R8 txrdy_n mode0" : "R12 txrdy_n fifo off", txrdy_n, c != 0);
        check(m == 0 ? "R9 rxrdy_n mode0" : "R12 rxrdy_n fifo off", rxrdy_n, c == 0);
      end
    end

    // R10: block mode transmit
    do_reset(); wr_mode(1, 1);
    for (int c = 0; c <= DEPTH; c++) begin
      tx_count = CW'(c); tick();
      check("R10 txrdy_n full only", txrdy_n, c == DEPTH);
    end

    // R11: block mode receive hysteresis
    do_reset(); wr_mode(1, 1); rx_trig = 3; exp_rx = 1;
    begin
      int seq [14] = '{0, 1, 2, 3, 4, 2, 1, 0, 1, 1, 2, 1, 0, 2};
      logic to [14] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0};
      for (int i = 0; i < 14; i++) begin
        rx_count = CW'(seq[i]); rx_timeout = to[i]; tick();
        if (seq[i] == 0) exp_rx = 1;
        else if (seq[i] >= 3 || to[i]) exp_rx = 0;
        check("R11 rxrdy_n block", rxrdy_n, exp_rx);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule